// File: doc/BRIEF.md
# Byte Arithmetic, Logic and Shift Unit

This block is the execute stage of a small load/store controller core. Each cycle it takes a source operand and a second operand, a four-bit operation code and a shift count, and drives a combinational result for the register file to write back. It also keeps a registered zero flag and carry flag, which a branch unit samples to resolve the four flag-based conditional branches.

The flags change only on a clock edge where the execute strobe is high, so a stalled or idle pipeline leaves them alone. Subtraction reports a borrow in the carry flag. A subtract whose result is thrown away therefore works as an unsigned compare. The carry-chained add and subtract read the stored carry, so multi-byte arithmetic is done one byte per executed operation.

Top module: `byte_alu`

## Requirements
- R1: Opcode 0 (add) gives result = a + b mod 256, and C is set to the carry out of bit 7. Opcode 1 (add with carry) gives a + b + C, with C set to its carry out.
- R2: Opcode 2 (subtract) gives a - b mod 256 (a minus b). C is set exactly when b is unsigned-greater than a, which is the borrow. Opcode 3 (subtract with carry) gives a - b - C, and C is set to its borrow.
- R3: Opcodes 4, 5, 6 and 7 give a AND b, a OR b, a XOR b and a AND NOT b, in that order. Each of them clears C.
- R4: Opcodes 8 and 9 shift a left or right by the 3-bit count and fill with zeros. For a nonzero count, C takes the last bit shifted out: bit 8-n of a for a left shift and bit n-1 of a for a right shift.
- R5: Opcodes 10 and 11 rotate a left or right by the count. For a nonzero count, C takes the last bit carried across the word boundary. For a left rotate this is bit 0 of the result, and for a right rotate it is bit 7 of the result.
- R6: For any shift or rotate with a count of 0, the result equals a and C keeps its value.
- R7: On every executed operation, Z is set when the 8-bit result is zero and cleared otherwise.
- R8: When the execute strobe is low at a clock edge, neither flag changes, while the result still follows the inputs in the same cycle.
- R9: A synchronous reset, active high, clears both Z and C.
- R10: Opcodes 12 to 15 pass a to the result unchanged and leave C as it is. Z still follows the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| exec_en | input | 1 | Execute strobe; the flags update on an edge where it is high |
| opcode | input | 4 | Operation select |
| src_a | input | 8 | Source operand (a) |
| src_b | input | 8 | Second operand (b) |
| shamt | input | 3 | Shift or rotate count |
| result | output | 8 | Combinational result |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry/borrow flag |

## Verification
The assertions assume that the opcode, both operands and the count are stable and known across each clock edge where the execute strobe is high, because the flag checks compare against the sampled values from that edge. The bench changes inputs only on the falling edge and raises the strobe for exactly one rising edge per operation. It also holds reset for whole cycles, so every sampled edge sees one clean operation.

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     exec_en,
  input  logic [3:0]               opcode,
  input  logic [WIDTH-1:0]         src_a,
  input  logic [WIDTH-1:0]         src_b,
  input  logic [$clog2(WIDTH)-1:0] shamt,
  output logic [WIDTH-1:0]         result,
  output logic                     flag_z,
  output logic                     flag_c
);

  localparam int CW = $clog2(WIDTH);

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4;
  localparam logic [3:0] OP_OR  = 4'd5;
  localparam logic [3:0] OP_XOR = 4'd6;
  localparam logic [3:0] OP_MSK = 4'd7;
  localparam logic [3:0] OP_SHL = 4'd8;
  localparam logic [3:0] OP_SHR = 4'd9;
  localparam logic [3:0] OP_ROL = 4'd10;
  localparam logic [3:0] OP_ROR = 4'd11;

  logic               cin_add, cin_sub;
  logic [WIDTH:0]     add_full, sub_full, shl_full, shr_full;
  logic [2*WIDTH-1:0] dbl, rol_full, ror_full;
  logic [WIDTH-1:0]   rol_res, ror_res;
  logic               cnt_zero;
  logic               c_next, c_load;

  assign cin_add  = (opcode == OP_ADC) & flag_c;
  assign cin_sub  = (opcode == OP_SBC) & flag_c;
  assign add_full = {1'b0, src_a} + {1'b0, src_b} + {{WIDTH{1'b0}}, cin_add};
  assign sub_full = {1'b0, src_a} - {1'b0, src_b} - {{WIDTH{1'b0}}, cin_sub};

  assign shl_full = {1'b0, src_a} << shamt;
  assign shr_full = {src_a, 1'b0} >> shamt;
  assign dbl      = {src_a, src_a};
  assign rol_full = dbl << shamt;
  assign ror_full = dbl >> shamt;
  assign rol_res  = rol_full[2*WIDTH-1:WIDTH];
  assign ror_res  = ror_full[WIDTH-1:0];
  assign cnt_zero = (shamt == {CW{1'b0}});

  always_comb begin
    result = src_a;
    c_next = flag_c;
    c_load = 1'b0;
    case (opcode)
      OP_ADD, OP_ADC: begin
        result = add_full[WIDTH-1:0];
        c_next = add_full[WIDTH];
        c_load = 1'b1;
      end
      OP_SUB, OP_SBC: begin
        result = sub_full[WIDTH-1:0];
        c_next = sub_full[WIDTH];
        c_load = 1'b1;
      end
      OP_AND: begin result = src_a & src_b;  c_next = 1'b0; c_load = 1'b1; end
      OP_OR:  begin result = src_a | src_b;  c_next = 1'b0; c_load = 1'b1; end
      OP_XOR: begin result = src_a ^ src_b;  c_next = 1'b0; c_load = 1'b1; end
      OP_MSK: begin result = src_a & ~src_b; c_next = 1'b0; c_load = 1'b1; end
      OP_SHL: begin
        result = shl_full[WIDTH-1:0];
        c_next = shl_full[WIDTH];
        c_load = !cnt_zero;
      end
      OP_SHR: begin
        result = shr_full[WIDTH:1];
        c_next = shr_full[0];
        c_load = !cnt_zero;
      end
      OP_ROL: begin
        result = rol_res;
        c_next = rol_res[0];
        c_load = !cnt_zero;
      end
      OP_ROR: begin
        result = ror_res;
        c_next = ror_res[WIDTH-1];
        c_load = !cnt_zero;
      end
      default: begin
        result = src_a;
        c_load = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else if (exec_en) begin
      flag_z <= (result == {WIDTH{1'b0}});
      if (c_load) flag_c <= c_next;
    end
  end

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (!flag_z && !flag_c));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> ($stable(flag_z) && $stable(flag_c)));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> (flag_z == ($past(result) == {WIDTH{1'b0}})));

  p_sub_borrow_r2: assert property (@(posedge clk) disable iff (rst)
    (exec_en && opcode == OP_SUB) |=> (flag_c == ($past(src_b) > $past(src_a))));

  p_logic_clears_c_r3: assert property (@(posedge clk) disable iff (rst)
    (exec_en && opcode[3:2] == 2'b01) |=> !flag_c);

  p_zero_count_keeps_c_r6: assert property (@(posedge clk) disable iff (rst)
    (exec_en && opcode[3:2] == 2'b10 && shamt == {CW{1'b0}}) |=> $stable(flag_c));

  p_spare_keeps_c_r10: assert property (@(posedge clk) disable iff (rst)
    (exec_en && opcode[3:2] == 2'b11) |=> $stable(flag_c));

endmodule

// File: tb/tb_byte_alu.sv
module tb_byte_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_en = 1'b0;
  logic [3:0] opcode = 4'd0;
  logic [7:0] src_a = 8'd0;
  logic [7:0] src_b = 8'd0;
  logic [2:0] shamt = 3'd0;
  logic [7:0] result;
  logic       flag_z, flag_c;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  byte_alu dut (
    .clk(clk), .rst(rst), .exec_en(exec_en), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .shamt(shamt),
    .result(result), .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [3:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic [2:0] n,
                        input logic [7:0] er, input logic ez, input logic ec);
    @(negedge clk);
    opcode = op; src_a = a; src_b = b; shamt = n;
    #1;
    check(req, "result", int'(result), int'(er));
    exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
    check(req, "Z", int'(flag_z), int'(ez));
    check(req, "C", int'(flag_c), int'(ec));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R9", "Z after reset", int'(flag_z), 0);
    check("R9", "C after reset", int'(flag_c), 0);
  endtask

  task automatic t_add;
    run_op("R1", 4'd0, 8'h3C, 8'h14, 3'd0, 8'h50, 1'b0, 1'b0);
    run_op("R1", 4'd0, 8'hFF, 8'h01, 3'd0, 8'h00, 1'b1, 1'b1);
    run_op("R1", 4'd1, 8'h10, 8'h20, 3'd0, 8'h31, 1'b0, 1'b0);
    run_op("R1", 4'd1, 8'h10, 8'h20, 3'd0, 8'h30, 1'b0, 1'b0);
  endtask

  task automatic t_sub;
    run_op("R2", 4'd2, 8'h50, 8'h20, 3'd0, 8'h30, 1'b0, 1'b0);
    run_op("R2", 4'd2, 8'h20, 8'h50, 3'd0, 8'hD0, 1'b0, 1'b1);
    run_op("R2", 4'd2, 8'h42, 8'h42, 3'd0, 8'h00, 1'b1, 1'b0);
    run_op("R2", 4'd2, 8'h00, 8'h01, 3'd0, 8'hFF, 1'b0, 1'b1);
    run_op("R2", 4'd3, 8'h10, 8'h05, 3'd0, 8'h0A, 1'b0, 1'b0);
    run_op("R2", 4'd3, 8'h05, 8'h05, 3'd0, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_logic;
    run_op("R3", 4'd2, 8'h00, 8'h01, 3'd0, 8'hFF, 1'b0, 1'b1);
    run_op("R3", 4'd4, 8'hF0, 8'h3C, 3'd0, 8'h30, 1'b0, 1'b0);
    run_op("R3", 4'd5, 8'hA0, 8'h05, 3'd0, 8'hA5, 1'b0, 1'b0);
    run_op("R3", 4'd6, 8'hFF, 8'hFF, 3'd0, 8'h00, 1'b1, 1'b0);
    run_op("R3", 4'd2, 8'h00, 8'h01, 3'd0, 8'hFF, 1'b0, 1'b1);
    run_op("R3", 4'd7, 8'hF6, 8'h14, 3'd0, 8'hE2, 1'b0, 1'b0);
  endtask

  task automatic t_shift;
    run_op("R4", 4'd8, 8'h81, 8'h00, 3'd1, 8'h02, 1'b0, 1'b1);
    run_op("R4", 4'd8, 8'h40, 8'h00, 3'd2, 8'h00, 1'b1, 1'b1);
    run_op("R4", 4'd9, 8'h05, 8'h00, 3'd1, 8'h02, 1'b0, 1'b1);
    run_op("R4", 4'd9, 8'h80, 8'h00, 3'd7, 8'h01, 1'b0, 1'b0);
  endtask

  task automatic t_rotate;
    run_op("R5", 4'd10, 8'h81, 8'h00, 3'd1, 8'h03, 1'b0, 1'b1);
    run_op("R5", 4'd10, 8'h12, 8'h00, 3'd4, 8'h21, 1'b0, 1'b1);
    run_op("R5", 4'd11, 8'h10, 8'h00, 3'd2, 8'h04, 1'b0, 1'b0);
    run_op("R5", 4'd11, 8'h01, 8'h00, 3'd1, 8'h80, 1'b0, 1'b1);
    run_op("R5", 4'd11, 8'h0E, 8'h00, 3'd3, 8'hC1, 1'b0, 1'b1);
  endtask

  task automatic t_zero_count;
    run_op("R6", 4'd8, 8'h5A, 8'h00, 3'd0, 8'h5A, 1'b0, 1'b1);
    run_op("R6", 4'd2, 8'h50, 8'h20, 3'd0, 8'h30, 1'b0, 1'b0);
    run_op("R6", 4'd11, 8'h00, 8'h00, 3'd0, 8'h00, 1'b1, 1'b0);
    run_op("R6", 4'd10, 8'h80, 8'h00, 3'd0, 8'h80, 1'b0, 1'b0);
  endtask

  task automatic t_idle;
    run_op("R8", 4'd0, 8'hFF, 8'h01, 3'd0, 8'h00, 1'b1, 1'b1);
    @(negedge clk);
    opcode = 4'd4; src_a = 8'h0F; src_b = 8'h0C; shamt = 3'd0;
    #1;
    check("R8", "result while idle", int'(result), 8'h0C);
    repeat (2) @(negedge clk);
    check("R8", "Z held", int'(flag_z), 1);
    check("R8", "C held", int'(flag_c), 1);
  endtask

  task automatic t_spare;
    run_op("R10", 4'd12, 8'h77, 8'h11, 3'd3, 8'h77, 1'b0, 1'b1);
    run_op("R10", 4'd15, 8'h00, 8'hFF, 3'd5, 8'h00, 1'b1, 1'b1);
    run_op("R7", 4'd6, 8'h3C, 8'h3C, 3'd0, 8'h00, 1'b1, 1'b0);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_rotate();
    t_zero_count();
    t_idle();
    t_spare();
    t_reset();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule